// File: doc/BRIEF.md
# Universal Bus Driver Register

This block carries a parameterised data word (18 bits by default) from an input bus to an output bus through one storage bit per lane. A single storage bank works in one of two ways, chosen at run time by a latch-enable input. With latch-enable high the bank is transparent and the output follows the input without waiting for a clock. With latch-enable low the bank becomes an edge-triggered register that samples the input on each rising clock edge. The block is used where one part must sometimes pass data straight through and at other times present a registered copy, with the choice switched on the fly.

An active-high output enable acts only on the output drivers: when it is high the drivers release the bus, and storage goes on capturing underneath. Every input lane has a keeper. At the logic level this is a per-lane `a_driven` qualifier. When a lane's qualifier is low, its line is taken to be floating, and the keeper supplies the last level seen while the lane was driven. An active-low reset clears storage and keepers to zero.

A small source-select state machine picks which storage element the held output comes from. Its states are `SRC_LATCH` and `SRC_FLOP`. Reset enters `SRC_LATCH`, and so does any high level on latch-enable (asynchronous). The transition `SRC_LATCH -> SRC_FLOP` happens on a rising clock edge while latch-enable is low. `SRC_FLOP` stays put on further clock edges and leaves only on reset or when latch-enable rises. In `SRC_LATCH` the held value is what the latch froze when latch-enable fell. In `SRC_FLOP` it is the word captured on the most recent rising clock edge.

Top module: `univ_bus_register`

## Requirements
- R1: The data path width is the parameter WIDTH (default 18); lane i of `y_bus` carries lane i of the input.
- R2: While `le` is 1, `y_bus` equals the keeper-resolved input in the same cycle, whatever `clk` does.
- R3: While `le` is 0, the keeper-resolved input present at a rising edge of `clk` appears on `y_bus` after that edge.
- R4: While `le` is 0 and `clk` stays steady at 1 or at 0, `y_bus` does not change when the input changes.
- R5: `oe` = 1 makes `y_drive` 0 and releases `y_bus` to high impedance; `oe` = 0 makes `y_drive` 1 and `y_bus` drives the stored value.
- R6: When `a_driven[i]` is 0, lane i takes the value `a_bus[i]` last had while `a_driven[i]` was 1; when it is 1, lane i takes `a_bus[i]`.
- R7: When `le` falls, the value passing through at that moment is held until the next rising `clk` edge or until `le` rises again.
- R8: Capture and hold work the same while `oe` = 1; a word clocked in during high impedance shows up once `oe` returns to 0.
- R9: While `rst_n` is 0, storage and keepers are cleared to zero and the source select returns to `SRC_LATCH`, so with `le` = 0 and `oe` = 0 the output reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge active when `le` is low |
| rst_n | input | 1 | Asynchronous active-low clear of storage and keepers |
| le | input | 1 | 1 = transparent, 0 = edge-triggered capture |
| oe | input | 1 | 1 = outputs in high impedance, 0 = outputs driven |
| a_bus | input | WIDTH | Input data lanes |
| a_driven | input | WIDTH | Per-lane flag: 1 = lane actively driven, 0 = floating |
| y_bus | output | WIDTH | Tri-state output data |
| y_drive | output | 1 | 1 while the output drivers are active |

## Verification
The main function is exercised with alternating bit patterns, all-ones, sparse words and mixed-lane words. Each is applied in transparent mode and in clocked mode, and they are chosen so that a stuck lane or swapped source shows as a wrong bit. Words that change while `le` falls, while `clk` sits high and while `clk` sits low separate a latch that froze at the fall from one that kept following, and separate edge capture from level capture. Partial and full release of `a_driven` after distinct driven words tell a working keeper from one that passes the raw bus or reads zero. A word clocked in under high impedance and read out after the enable returns shows whether the enable reaches into storage.

// File: rtl/ubd_pkg.sv
`timescale 1ns/1ps
package ubd_pkg;
    localparam int UBD_WIDTH = 18;

    typedef enum logic {
        SRC_LATCH = 1'b0,
        SRC_FLOP  = 1'b1
    } src_t;
endpackage

// File: rtl/ubd_keeper.sv
`timescale 1ns/1ps
// Per-lane bus keeper: a floating lane reads its last driven level.
module ubd_keeper #(
    parameter int WIDTH = ubd_pkg::UBD_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin,
    input  logic [WIDTH-1:0] driven,
    output logic [WIDTH-1:0] resolved
);
    logic [WIDTH-1:0] keep_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        always_latch begin
            if (!rst_n)
                keep_q[i] <= 1'b0;
            else if (driven[i])
                keep_q[i] <= pin[i];
        end

        assign resolved[i] = driven[i] ? pin[i] : keep_q[i];

        // R6: a lane left floating across two edges keeps its level
        p_keep_floating_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!driven[i] && $past(!driven[i])) |-> $stable(resolved[i]));
    end
endmodule

// File: rtl/ubd_store.sv
`timescale 1ns/1ps
// Storage bank: latch path, flop path and the source-select state machine.
module ubd_store #(
    parameter int WIDTH = ubd_pkg::UBD_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             le,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output ubd_pkg::src_t    src
);
    import ubd_pkg::*;

    logic [WIDTH-1:0] lat_q;
    logic [WIDTH-1:0] flop_q;
    src_t             src_q;

    // Latch path: open while le is high, frozen at its fall.
    always_latch begin
        if (!rst_n)
            lat_q <= '0;
        else if (le)
            lat_q <= d;
    end

    // Flop path: samples every rising edge; only read in SRC_FLOP.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flop_q <= '0;
        else
            flop_q <= d;
    end

    // State register: le high forces SRC_LATCH, a clock edge with le low
    // moves to SRC_FLOP.
    always_ff @(posedge clk or posedge le or negedge rst_n) begin
        if (!rst_n)
            src_q <= SRC_LATCH;
        else if (le)
            src_q <= SRC_LATCH;
        else
            src_q <= SRC_FLOP;
    end

    // Output process.
    always_comb begin
        if (le) begin
            q = d;
        end else begin
            unique case (src_q)
                SRC_LATCH: q = lat_q;
                SRC_FLOP:  q = flop_q;
            endcase
        end
    end

    assign src = src_q;
endmodule

// File: rtl/ubd_driver.sv
`timescale 1ns/1ps
// Tri-state output stage.
module ubd_driver #(
    parameter int WIDTH = ubd_pkg::UBD_WIDTH
) (
    input  logic             oe,
    input  logic [WIDTH-1:0] val,
    output logic [WIDTH-1:0] pad,
    output logic             drive
);
    assign drive = !oe;
    assign pad   = drive ? val : {WIDTH{1'bz}};
endmodule

// File: rtl/univ_bus_register.sv
`timescale 1ns/1ps
module univ_bus_register #(
    parameter int WIDTH = ubd_pkg::UBD_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             le,
    input  logic             oe,
    input  logic [WIDTH-1:0] a_bus,
    input  logic [WIDTH-1:0] a_driven,
    output logic [WIDTH-1:0] y_bus,
    output logic             y_drive
);
    import ubd_pkg::*;

    logic [WIDTH-1:0] a_eff;
    logic [WIDTH-1:0] held;
    src_t             src;

    ubd_keeper #(.WIDTH(WIDTH)) u_keeper (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (a_bus),
        .driven   (a_driven),
        .resolved (a_eff)
    );

    ubd_store #(.WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (le),
        .d     (a_eff),
        .q     (held),
        .src   (src)
    );

    ubd_driver #(.WIDTH(WIDTH)) u_driver (
        .oe    (oe),
        .val   (held),
        .pad   (y_bus),
        .drive (y_drive)
    );

    // R2: transparent mode passes the resolved input to the pins
    p_transparent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (le && !oe) |-> (y_bus == a_eff));

    // R3: in SRC_FLOP the held word is the one present at the previous edge
    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && $past(!le) && src == SRC_FLOP) |-> (held == $past(a_eff)));

    // R5: enabled drivers show the stored value
    p_drive_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe) |-> (y_drive && y_bus == held));
endmodule

// File: tb/tb_univ_bus_register.sv
`timescale 1ns/1ps
module tb_univ_bus_register;
    localparam int W = 18;
    localparam int NV = 14;

    typedef struct packed {
        logic         le;
        logic         oe;
        logic         pulse;
        logic [W-1:0] a;
        logic [W-1:0] drv;
        logic [W-1:0] exp_y;
        logic         exp_en;
    } vec_t;

    localparam logic [W-1:0] ALL = 18'h3FFFF;

    // Order matters: each row builds on state left by the previous ones.
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b0, 18'h15555, ALL,      18'h15555, 1'b1}, // R2
        '{1'b1, 1'b0, 1'b0, 18'h2AAAA, ALL,      18'h2AAAA, 1'b1}, // R2
        '{1'b0, 1'b0, 1'b0, 18'h3FFFF, ALL,      18'h2AAAA, 1'b1}, // R7
        '{1'b0, 1'b0, 1'b1, 18'h3FFFF, ALL,      18'h3FFFF, 1'b1}, // R3
        '{1'b0, 1'b0, 1'b0, 18'h00F0F, ALL,      18'h3FFFF, 1'b1}, // R4
        '{1'b0, 1'b1, 1'b1, 18'h00F0F, ALL,      18'h00000, 1'b0}, // R5
        '{1'b0, 1'b0, 1'b0, 18'h12345, ALL,      18'h00F0F, 1'b1}, // R8
        '{1'b0, 1'b0, 1'b1, 18'h12345, ALL,      18'h12345, 1'b1}, // R3
        '{1'b1, 1'b0, 1'b0, 18'h00000, 18'h3FF00, 18'h00045, 1'b1}, // R6
        '{1'b1, 1'b0, 1'b0, 18'h3FFFF, 18'h00000, 18'h00045, 1'b1}, // R6
        '{1'b1, 1'b0, 1'b0, 18'h3C3C3, ALL,      18'h3C3C3, 1'b1}, // R1
        '{1'b0, 1'b0, 1'b1, 18'h00000, 18'h00000, 18'h3C3C3, 1'b1}, // R6
        '{1'b1, 1'b1, 1'b0, 18'h0000A, ALL,      18'h00000, 1'b0}, // R5
        '{1'b0, 1'b0, 1'b0, 18'h11111, ALL,      18'h0000A, 1'b1}  // R7
    };

    localparam string TAG [NV] = '{"R2", "R2", "R7", "R3", "R4", "R5", "R8",
                                   "R3", "R6", "R6", "R1", "R6", "R5", "R7"};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         le = 1'b0;
    logic         oe = 1'b0;
    logic [W-1:0] a_bus = '0;
    logic [W-1:0] a_driven = ALL;
    wire  [W-1:0] y_bus;
    wire          y_drive;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    univ_bus_register #(.WIDTH(W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .le       (le),
        .oe       (oe),
        .a_bus    (a_bus),
        .a_driven (a_driven),
        .y_bus    (y_bus),
        .y_drive  (y_drive)
    );

    task automatic check(input string req, input logic [W-1:0] exp_y, input logic exp_en);
        checks++;
        if (y_drive !== exp_en) begin
            failures++;
            $display("FAIL %s drive: actual=%0b expected=%0b", req, y_drive, exp_en);
        end else if (exp_en && y_bus !== exp_y) begin
            failures++;
            $display("FAIL %s y_bus: actual=%h expected=%h", req, y_bus, exp_y);
        end
    endtask

    // One 100 MHz clock pulse.
    task automatic pulse();
        clk = 1'b1;
        #5;
        clk = 1'b0;
        #5;
    endtask

    // Drop le before moving data; raise it after, so the latch never races.
    task automatic apply(input vec_t v);
        if (!v.le) begin
            le = 1'b0;
            #1;
        end
        oe = v.oe;
        a_bus = v.a;
        a_driven = v.drv;
        #1;
        le = v.le;
        #1;
        if (v.pulse) pulse();
        #1;
    endtask

    initial begin
        #1ms;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R9: reset state, including a clock edge during reset
        a_bus = 18'h2BEEF;
        #3;
        pulse();
        check("R9", 18'h00000, 1'b1);
        oe = 1'b1;
        #2;
        check("R5", 18'h00000, 1'b0);
        oe = 1'b0;
        rst_n = 1'b1;
        #3;
        check("R9", 18'h00000, 1'b1);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            check(TAG[i], VEC[i].exp_y, VEC[i].exp_en);
        end

        // R3/R4: edge capture, then steady-high and steady-low clock
        a_bus = 18'h21212;
        #2;
        clk = 1'b1;
        #2;
        check("R3", 18'h21212, 1'b1);
        a_bus = 18'h02222;
        #3;
        check("R4", 18'h21212, 1'b1);
        clk = 1'b0;
        #2;
        a_bus = 18'h03333;
        #3;
        check("R4", 18'h21212, 1'b1);

        // R2: transparency ignores the clock and tracks immediately
        le = 1'b1;
        a_bus = 18'h0ABCD;
        pulse();
        check("R2", 18'h0ABCD, 1'b1);
        a_bus = 18'h00001;
        #2;
        check("R2", 18'h00001, 1'b1);

        // R7: after a flop capture, a new le high/low window re-freezes
        a_bus = 18'h1F00F;
        #2;
        le = 1'b0;
        #1;
        a_bus = 18'h00000;
        #2;
        check("R7", 18'h1F00F, 1'b1);

        // R9: mid-run reset clears storage
        rst_n = 1'b0;
        #2;
        check("R9", 18'h00000, 1'b1);
        rst_n = 1'b1;
        #3;
        check("R9", 18'h00000, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule